// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character FIFO and Request-to-Send

This block receives asynchronous serial characters on a single line. Timing comes from a 16x oversampling clock enable. The line first passes through a two-flop synchronizer.

A start bit counts only after eight consecutive low samples taken on ticks. Each later bit is sampled once, sixteen ticks after the previous sample, which places the sample near the bit centre. The block collects 5 to 8 data bits, least significant first. It then takes an optional parity bit and one stop bit.

Each finished character goes into a three-entry holding FIFO together with four status flags: parity error, framing error, overrun and break. A read strobe removes the oldest entry. A request-to-send output is raised by a command and dropped by the receiver itself when a character is lost to a full FIFO. Two line conditions get special handling:
- A low stop bit on a character that is not a break can run straight into the next character.
- A long break is stored once.

Top module: `uart_rx_fc`

## Requirements
- R1: A low pulse on the line that covers fewer than eight consecutive oversampling ticks is rejected and stores no character.
- R2: The character length field selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits. Bits arrive least significant first, and the stored byte has every bit above the character length at zero.
- R3: Parity mode 01 is even, 10 is odd, and 00 or 11 means no parity bit. The parity error flag of a character is 1 when the received parity bit differs from the bit computed over its data.
- R4: A character that is not a break and whose stop bit is sampled low is stored with its framing error flag set.
- R5: After such a framing error, if the line stays low for another half bit, that low period serves as the next start bit. The following character is received without any new falling edge.
- R6: A character that starts right after a valid stop bit, with no idle time between them, is received.
- R7: A break is all data bits zero, a zero parity bit when parity is on, and a zero stop bit. It is stored once as data 0 with the break flag set, and no further character is stored until the line has returned high.
- R8: The FIFO holds 3 entries. The ready flag is 1 while at least one entry is stored, and the full flag is 1 when all 3 are stored. The data and flag outputs show the oldest entry. A read strobe removes that entry, and a read strobe on an empty FIFO changes nothing.
- R9: A character that completes while the FIFO is full is discarded. The stored entries are kept, and the overrun flag of the newest stored entry is set.
- R10: The RTS assert command sets the RTS output to 1. An overrun clears it to 0, and when both fall in the same cycle the overrun wins.
- R11: When a read strobe and a completing character fall in the same cycle with the FIFO full, the read is taken first. The character is stored and no overrun occurs.
- R12: While the receiver enable is low, the receiver returns to hunting for a start bit and any partly received character is dropped.
- R13: After reset the ready, full and RTS outputs are 0, and the data and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Oversampling enable, sixteen per bit time |
| rx_en_i | input | 1 | Receiver enable |
| char_len_i | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_mode_i | input | 2 | 01 even, 10 odd, 00/11 none |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| rts_set_i | input | 1 | RTS assert command |
| rdy_o | output | 1 | At least one character stored |
| ffull_o | output | 1 | All FIFO entries occupied |
| data_o | output | 8 | Data of the oldest entry |
| perr_o | output | 1 | Parity error of the oldest entry |
| ferr_o | output | 1 | Framing error of the oldest entry |
| oerr_o | output | 1 | Overrun flag of the oldest entry |
| brk_o | output | 1 | Break flag of the oldest entry |
| rts_o | output | 1 | Request-to-send output |

## Verification
Two events can land in the same cycle: a character completing into a full FIFO, and a read strobe from the consumer. The bench sends one frame into an empty FIFO and records the latency from the first start-bit cycle to the cycle ready rises. It then fills the FIFO and sends a frame at the same tick phase, with a read strobe placed exactly on that cycle. The reference model expects the read to win: three entries remain, the new character is last, no overrun flag is set and RTS stays high. Any other outcome is reported on the next compared cycle.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_FWAIT,
        RX_BWAIT
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       oerr;
        logic       brk;
    } rx_entry_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/rxfc_sync.sv
module rxfc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.sh <= '1;
        else        s_q    <= s_d;
    end

    assign q_o = s_q.sh[STAGES-1];

endmodule

// File: rtl/rxfc_deser.sv
module rxfc_deser
    import rxfc_pkg::*;
#(
    parameter int OVS = 16,
    localparam int HALF = OVS / 2,
    localparam int CW   = $clog2(OVS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       tick_i,
    input  logic       line_i,
    input  logic [1:0] char_len_i,
    input  logic [1:0] par_mode_i,
    output logic       push_o,
    output rx_entry_t  ent_o
);

    typedef struct packed {
        rx_state_e   st;
        logic [CW-1:0] tcnt;
        logic [2:0]  bidx;
        logic [7:0]  data;
        logic        pbit;
        logic        prev;
        logic        push;
        rx_entry_t   ent;
    } deser_s;

    deser_s q, n;

    logic par_en;
    logic last_bit;
    logic par_calc;
    logic brk_hit;
    logic at_bit;
    logic at_half;

    always_comb begin
        par_en   = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
        last_bit = (q.bidx == (3'd4 + {1'b0, char_len_i}));
        par_calc = (^q.data) ^ (par_mode_i == PAR_ODD);
        brk_hit  = !line_i && (q.data == 8'd0) && (!par_en || !q.pbit);
        at_bit   = (q.tcnt == CW'(OVS - 1));
        at_half  = (q.tcnt == CW'(HALF - 1));

        n      = q;
        n.push = 1'b0;

        if (!en_i) begin
            n.st   = RX_HUNT;
            n.tcnt = '0;
        end else if (tick_i) begin
            n.prev = line_i;
            unique case (q.st)
                RX_HUNT: begin
                    if (q.prev && !line_i) begin
                        n.st   = RX_START;
                        n.tcnt = CW'(1);
                    end
                end
                RX_START: begin
                    if (line_i) begin
                        n.st = RX_HUNT;
                    end else if (at_half) begin
                        n.st   = RX_DATA;
                        n.tcnt = '0;
                        n.bidx = '0;
                        n.data = '0;
                        n.pbit = 1'b0;
                    end else begin
                        n.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_bit) begin
                        n.tcnt         = '0;
                        n.data[q.bidx] = line_i;
                        if (last_bit) n.st = par_en ? RX_PAR : RX_STOP;
                        else          n.bidx = q.bidx + 1'b1;
                    end else begin
                        n.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_bit) begin
                        n.tcnt = '0;
                        n.pbit = line_i;
                        n.st   = RX_STOP;
                    end else begin
                        n.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_bit) begin
                        n.tcnt       = '0;
                        n.push       = 1'b1;
                        n.ent.data   = q.data;
                        n.ent.oerr   = 1'b0;
                        n.ent.perr   = par_en && (q.pbit != par_calc);
                        if (line_i) begin
                            n.ent.ferr = 1'b0;
                            n.ent.brk  = 1'b0;
                            n.st       = RX_HUNT;
                        end else if (brk_hit) begin
                            n.ent.data = 8'd0;
                            n.ent.perr = 1'b0;
                            n.ent.ferr = 1'b0;
                            n.ent.brk  = 1'b1;
                            n.st       = RX_BWAIT;
                        end else begin
                            n.ent.ferr = 1'b1;
                            n.ent.brk  = 1'b0;
                            n.st       = RX_FWAIT;
                        end
                    end else begin
                        n.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_FWAIT: begin
                    if (line_i) begin
                        n.st = RX_HUNT;
                    end else if (at_half) begin
                        n.st   = RX_START;
                        n.tcnt = '0;
                    end else begin
                        n.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_BWAIT: begin
                    if (line_i) n.st = RX_HUNT;
                end
                default: n.st = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_HUNT;
            q.prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign push_o = q.push;
    assign ent_o  = q.ent;

    // R12
    dis_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> q.st == RX_HUNT);

    // R6
    push_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> $past(tick_i));

    // R4
    ferr_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> !(q.ent.ferr && q.ent.brk));

    // R2
    short_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n.push && char_len_i == 2'b00) |=> q.ent.data[7:5] == 3'b000);

endmodule

// File: rtl/rxfc_fifo.sv
module rxfc_fifo
    import rxfc_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t ent_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      rdy_o,
    output logic      full_o,
    output logic      ovf_o
);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [CNTW-1:0]       cnt;
    } fifo_s;

    fifo_s q, n;

    logic            do_pop;
    logic            is_full;
    logic [CNTW-1:0] c;

    assign is_full = (q.cnt == CNTW'(DEPTH));
    assign do_pop  = pop_i && (q.cnt != '0);
    assign ovf_o   = push_i && !do_pop && is_full;

    always_comb begin
        n = q;
        c = q.cnt;
        if (do_pop) begin
            for (int i = 0; i < DEPTH - 1; i++) n.mem[i] = q.mem[i+1];
            c = c - 1'b1;
        end
        if (push_i) begin
            if (c < CNTW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNTW'(i) == c) n.mem[i] = ent_i;
                end
                c = c + 1'b1;
            end else begin
                n.mem[DEPTH-1].oerr = 1'b1;
            end
        end
        n.cnt = c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign head_o = q.mem[0];
    assign rdy_o  = (q.cnt != '0);
    assign full_o = is_full;

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNTW'(DEPTH));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && q.cnt == '0 && !push_i) |=> q.cnt == '0);

    // R9
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (q.cnt == CNTW'(DEPTH)) && (q.mem[0].data == $past(q.mem[0].data)));

    // R11
    swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && is_full) |=> (q.cnt == CNTW'(DEPTH)) && !q.mem[DEPTH-1].oerr);

endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
    import rxfc_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 3,
    parameter int SYNC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick16_i,
    input  logic       rx_en_i,
    input  logic [1:0] char_len_i,
    input  logic [1:0] par_mode_i,
    input  logic       rd_i,
    input  logic       rts_set_i,
    output logic       rdy_o,
    output logic       ffull_o,
    output logic [7:0] data_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       oerr_o,
    output logic       brk_o,
    output logic       rts_o
);

    logic      line_s;
    logic      push;
    logic      ovf;
    rx_entry_t ent;
    rx_entry_t head;

    rxfc_sync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (line_s)
    );

    rxfc_deser #(.OVS(OVS)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (rx_en_i),
        .tick_i     (tick16_i),
        .line_i     (line_s),
        .char_len_i (char_len_i),
        .par_mode_i (par_mode_i),
        .push_o     (push),
        .ent_o      (ent)
    );

    rxfc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .ent_i  (ent),
        .pop_i  (rd_i),
        .head_o (head),
        .rdy_o  (rdy_o),
        .full_o (ffull_o),
        .ovf_o  (ovf)
    );

    typedef struct packed {
        logic rts;
    } flow_s;

    flow_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (rts_set_i) f_d.rts = 1'b1;
        if (ovf)       f_d.rts = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rts_o  = f_q.rts;
    assign data_o = head.data;
    assign perr_o = head.perr;
    assign ferr_o = head.ferr;
    assign oerr_o = head.oerr;
    assign brk_o  = head.brk;

    // R10
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !rts_o);

    // R10
    rts_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_set_i && !ovf) |=> rts_o);

    // R8
    full_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ffull_o |-> rdy_o);

endmodule

// File: tb/tb_uart_rx_fc.sv
module tb_uart_rx_fc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] clen = 2'b11;
    logic [1:0] pmode = 2'b00;
    logic       rd = 1'b0;
    logic       rts_set = 1'b0;
    logic       rdy_o, ffull_o, perr_o, ferr_o, oerr_o, brk_o, rts_o;
    logic [7:0] data_o;

    uart_rx_fc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx),
        .tick16_i   (tick),
        .rx_en_i    (rx_en),
        .char_len_i (clen),
        .par_mode_i (pmode),
        .rd_i       (rd),
        .rts_set_i  (rts_set),
        .rdy_o      (rdy_o),
        .ffull_o    (ffull_o),
        .data_o     (data_o),
        .perr_o     (perr_o),
        .ferr_o     (ferr_o),
        .oerr_o     (oerr_o),
        .brk_o      (brk_o),
        .rts_o      (rts_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick <= cyc[0];

    logic [11:0] mq[$];
    bit    m_rts = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R13";
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    int    frame_cyc = 0;
    bit    meas = 1'b0;
    bit    got = 1'b0;
    int    push_cyc = 0;
    int    lat = 0;

    task automatic chk(string tag, int act, int want);
        n_chk++;
        if (act != want) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, want, cyc);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (cmp_on && !done) begin
            chk({cur_req, " rdy"}, int'(rdy_o), int'(mq.size() != 0));
            chk({cur_req, " full"}, int'(ffull_o), int'(mq.size() == 3));
            chk({cur_req, " rts"}, int'(rts_o), int'(m_rts));
            if (mq.size() != 0)
                chk({cur_req, " head"}, int'({data_o, perr_o, ferr_o, oerr_o, brk_o}), int'(mq[0]));
        end
    end

    always @(posedge clk) begin
        #3;
        if (meas && !got && rdy_o) begin
            got = 1'b1;
            push_cyc = cyc;
        end
    end

    function automatic logic [11:0] expect_ent(logic [7:0] d, logic [1:0] len,
                                               logic [1:0] pm, bit pflip, bit stopv);
        int nb;
        logic [7:0] md;
        bit pen, pb;
        nb  = 5 + int'(len);
        md  = d & 8'((1 << nb) - 1);
        pen = (pm == 2'b01) || (pm == 2'b10);
        pb  = (^md) ^ (pm == 2'b10) ^ pflip;
        if (!stopv && md == 8'd0 && (!pen || !pb))
            return {8'h00, 1'b0, 1'b0, 1'b0, 1'b1};
        return {md, pen && pflip, !stopv, 1'b0, 1'b0};
    endfunction

    task automatic model_push(logic [11:0] e);
        logic [11:0] t;
        if (mq.size() < 3) begin
            mq.push_back(e);
        end else begin
            t = mq[2];
            t[1] = 1'b1;
            mq[2] = t;
            m_rts = 1'b0;
        end
    endtask

    task automatic align();
        while (cyc[0] != 1'b0) @(negedge clk);
    endtask

    task automatic bitx(logic v);
        rx = v;
        repeat (32) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, bit pflip, bit stopv, bit add);
        int nb;
        logic [7:0] md;
        bit pen, pb;
        align();
        cmp_on = 1'b0;
        frame_cyc = cyc;
        nb  = 5 + int'(clen);
        md  = d & 8'((1 << nb) - 1);
        pen = (pmode == 2'b01) || (pmode == 2'b10);
        pb  = (^md) ^ (pmode == 2'b10) ^ pflip;
        bitx(1'b0);
        for (int i = 0; i < nb; i++) bitx(d[i]);
        if (pen) bitx(pb);
        bitx(stopv);
        if (add) model_push(expect_ent(d, clen, pmode, pflip, stopv));
    endtask

    task automatic idle(int n);
        rx = 1'b1;
        repeat (n) @(negedge clk);
        cmp_on = 1'b1;
    endtask

    task automatic do_read();
        @(negedge clk);
        cmp_on = 1'b0;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
        cmp_on = 1'b1;
    endtask

    task automatic rts_cmd();
        @(negedge clk);
        cmp_on = 1'b0;
        rts_set = 1'b1;
        @(negedge clk);
        rts_set = 1'b0;
        m_rts = 1'b1;
        cmp_on = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R13";
        chk("R13 rdy", int'(rdy_o), 0);
        chk("R13 full", int'(ffull_o), 0);
        chk("R13 rts", int'(rts_o), 0);
        chk("R13 data+flags", int'({data_o, perr_o, ferr_o, oerr_o, brk_o}), 0);

        rx_en = 1'b1;
        idle(40);

        cur_req = "R10";
        rts_cmd();
        idle(10);

        // lengths, LSB first, zero padding
        cur_req = "R2";
        clen = 2'b11; pmode = 2'b00;
        send(8'hA7, 1'b0, 1'b1, 1'b1); idle(40);
        clen = 2'b00;
        send(8'hFF, 1'b0, 1'b1, 1'b1); idle(40);
        clen = 2'b10;
        send(8'hA5, 1'b0, 1'b1, 1'b1); idle(40);
        cur_req = "R8";
        do_read(); do_read(); do_read();
        do_read();
        idle(10);

        cur_req = "R3";
        clen = 2'b11; pmode = 2'b01;
        send(8'h53, 1'b0, 1'b1, 1'b1); idle(40);
        send(8'h53, 1'b1, 1'b1, 1'b1); idle(40);
        pmode = 2'b10;
        send(8'h0F, 1'b1, 1'b1, 1'b1); idle(40);
        do_read(); do_read(); do_read();

        cur_req = "R6";
        pmode = 2'b00;
        send(8'h11, 1'b0, 1'b1, 1'b1);
        send(8'h22, 1'b0, 1'b1, 1'b1);
        idle(40);
        do_read(); do_read();

        cur_req = "R5";
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        idle(60);
        do_read(); do_read();

        cur_req = "R4";
        send(8'h81, 1'b0, 1'b0, 1'b1);
        idle(200);
        do_read();

        cur_req = "R7";
        pmode = 2'b01;
        send(8'h00, 1'b0, 1'b0, 1'b1);
        rx = 1'b0;
        repeat (160) @(negedge clk);
        idle(60);
        do_read();
        pmode = 2'b00;

        cur_req = "R1";
        rx = 1'b0;
        repeat (12) @(negedge clk);
        idle(600);
        send(8'h96, 1'b0, 1'b1, 1'b1); idle(40);
        do_read();

        cur_req = "R12";
        align();
        cmp_on = 1'b0;
        bitx(1'b0); bitx(1'b1); bitx(1'b0); bitx(1'b1);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (4) @(negedge clk);
        rx_en = 1'b1;
        idle(600);

        cur_req = "R9";
        send(8'h31, 1'b0, 1'b1, 1'b1); idle(40);
        send(8'h32, 1'b0, 1'b1, 1'b1); idle(40);
        send(8'h33, 1'b0, 1'b1, 1'b1); idle(40);
        send(8'h34, 1'b0, 1'b1, 1'b1); idle(40);
        do_read(); do_read(); do_read();
        cur_req = "R10";
        rts_cmd();
        idle(10);

        cur_req = "R11";
        got = 1'b0; meas = 1'b1;
        send(8'h44, 1'b0, 1'b1, 1'b1); idle(20);
        meas = 1'b0;
        lat = push_cyc - frame_cyc;
        chk("R11 latency found", int'(got && lat > 10), 1);
        send(8'h45, 1'b0, 1'b1, 1'b1); idle(40);
        send(8'h46, 1'b0, 1'b1, 1'b1); idle(40);
        align();
        fork
            send(8'h47, 1'b0, 1'b1, 1'b0);
            begin
                repeat (lat - 1) @(negedge clk);
                rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
            end
        join
        void'(mq.pop_front());
        model_push(expect_ent(8'h47, clen, pmode, 1'b0, 1'b1));
        idle(40);
        do_read(); do_read(); do_read();
        idle(10);

        finish_run();
    end

endmodule